// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Line Interrupts

This block controls a bank of general-purpose lines from a simple 32-bit read/write register bus. Each line has its own configuration word. The word sets the pad drive value, turns the output driver off so that the line becomes an input, and turns the receiver off. The same word shows the synchronised input level and selects how the line raises an interrupt. A line can raise an interrupt on a rising edge, while its input is high, or not at all.

Each line's interrupt events latch into a status bit. Status bits and their enable bits are packed one word per group of 32 lines. A single interrupt output is high whenever some line has both its status bit and its enable bit set. Software acknowledges a line by writing 0 to its status bit.

A per-line lock bitmap is captured from an input port while reset is held. A locked line's configuration word is read-only on the bus. Writes to a locked line are dropped without any error response. The bus reaches every register through one movable window, whose offset is returned by the register at address 0x000.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration word reads 0x0080_0008: trigger field (bits 25:22) = 2, output-off (bit 3) = 1, all other bits 0. In this state pad_oe is 0, all status and enable words read 0, and irq is 0.
- R2: Address 0x000 reads the window offset (default 0x400). Inside the window, the lock words sit at +0x004+4k, status word k at +0x020+8k, enable word k at +0x024+8k, and the configuration word of line n at +0x100+4n. Reads return data on the clock after rd_en.
- R3: A configuration write stores bit 0 (drive), bit 3 (output off), bit 4 (receiver off) and bits 25:22 (trigger). Bits 2, 21:5 and 31:26 read 0. pad_out follows bit 0, and pad_oe is the inverse of bit 3.
- R4: Configuration bit 1 reads the input level after a two-flop synchroniser. The input is visible two clocks after it changes. Bit 1 reads 0 while the receiver is off.
- R5: With trigger = 1 (rising edge) and the receiver on, a 0-to-1 input transition sets the line's status bit on the third clock edge after the pad changes. A level that stays high after an acknowledge does not set the bit again.
- R6: With trigger = 0 (level high) and the receiver on, the status bit is set on every clock while the synchronised input is 1. It can be cleared only after the input has returned low.
- R7: Trigger = 2, trigger codes 3 to 15, or receiver off: the line never sets its status bit.
- R8: The status of line n is bit n%32 of status word n/32. Writing a status word clears the bits written 0 and leaves the bits written 1 unchanged.
- R9: If an event arrives in the same cycle as a clear of its status bit, the bit stays set.
- R10: irq is 1 exactly when some status bit and its matching enable bit are both 1. A pending status bit with enable 0 does not raise irq.
- R11: Lock bits are loaded from lock_init while rst_n is low and read back as lock word n/32, bit n%32. Writes to lock words have no effect. A configuration write to a locked line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; lock_init is captured while it is low |
| lock_init | input | 128 | Per-line lock bitmap loaded at reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pad_in | input | 128 | Line input levels, asynchronous |
| pad_out | output | 128 | Line drive values |
| pad_oe | output | 128 | Line output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Rising-edge mode is driven with a rise that is then held high across an acknowledge. This separates edge detection from level detection, and sampling irq on each clock of the rise pins the synchroniser latency. Level mode is cleared while the input is still high and again after it falls, which shows that a same-cycle event wins over a clear. The disabled code, an unsupported code and edge mode with the receiver off are each given a full pulse, and all three must leave status untouched. A locked line next to unlocked ones, and a masked pending bit next to an unmasked one, show that lock and enable act per line and per bank bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // configuration word bit positions (software-visible encoding)
   localparam int CFG_DRV_BIT   = 0;
   localparam int CFG_RXST_BIT  = 1;
   localparam int CFG_TXOFF_BIT = 3;
   localparam int CFG_RXOFF_BIT = 4;
   localparam int CFG_TRIG_LO   = 22;
   localparam int CFG_TRIG_W    = 4;

   localparam logic [CFG_TRIG_W-1:0] TRIG_LEVEL = 4'd0;
   localparam logic [CFG_TRIG_W-1:0] TRIG_RISE  = 4'd1;
   localparam logic [CFG_TRIG_W-1:0] TRIG_OFF   = 4'd2;

   typedef struct packed {
      logic [CFG_TRIG_W-1:0] trig;
      logic                  rx_off;
      logic                  tx_off;
      logic                  drv;
   } line_cfg_t;

   localparam line_cfg_t CFG_RESET = '{trig: TRIG_OFF, rx_off: 1'b0, tx_off: 1'b1, drv: 1'b0};

   function automatic logic [31:0] cfg_to_word(line_cfg_t c, logic rx_state);
      logic [31:0] w;
      w = '0;
      w[CFG_DRV_BIT]   = c.drv;
      w[CFG_RXST_BIT]  = rx_state;
      w[CFG_TXOFF_BIT] = c.tx_off;
      w[CFG_RXOFF_BIT] = c.rx_off;
      w[CFG_TRIG_LO +: CFG_TRIG_W] = c.trig;
      return w;
   endfunction

endpackage

// File: rtl/gpio_line_cell.sv
module gpio_line_cell
   import gpio_bank_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lock_in,
   input  logic        pad_in,
   input  logic        cfg_wr,
   input  line_cfg_t   wr_cfg,
   output logic [31:0] cfg_word,
   output logic        pad_out,
   output logic        pad_oe,
   output logic        locked,
   output logic        evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lock_q;
   line_cfg_t              cfg_q;
   logic                   in_s;
   logic                   rx_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   // lock captured only while reset is held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= lock_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q <= CFG_RESET;
      else if (cfg_wr && !lock_q) cfg_q <= wr_cfg;
   end

   assign in_s   = sync_q[SYNC_STAGES-1];
   assign rx_on  = !cfg_q.rx_off;
   assign evt    = rx_on && ((cfg_q.trig == TRIG_LEVEL && in_s) ||
                             (cfg_q.trig == TRIG_RISE && in_s && !prev_q));
   assign cfg_word = cfg_to_word(cfg_q, in_s && rx_on);
   assign pad_out  = cfg_q.drv;
   assign pad_oe   = !cfg_q.tx_off;
   assign locked   = lock_q;

   // R11
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(cfg_q));
   // R7
   off_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.rx_off || (cfg_q.trig != TRIG_LEVEL && cfg_q.trig != TRIG_RISE)) |-> !evt);
   // R5
   one_evt_per_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && cfg_q.trig == TRIG_RISE) |=> !(evt && cfg_q.trig == TRIG_RISE));

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             st_wr,
   input  logic             en_wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] status,
   output logic [WIDTH-1:0] enable,
   output logic             pend
);

   logic [WIDTH-1:0] status_q;
   logic [WIDTH-1:0] enable_q;
   logic [WIDTH-1:0] keep;

   assign keep = st_wr ? wdata : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= (status_q & keep) | evt;   // new event wins over clear
         if (en_wr) enable_q <= wdata;
      end
   end

   assign status = status_q;
   assign enable = enable_q;
   assign pend   = |(status_q & enable_q);

   // R8
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~$past(status_q) & ~$past(evt)) == '0);
   // R8
   ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_q) & ~status_q & ($past(st_wr) ? $past(wdata) : '1)) == '0);
   // R9
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt) & ~status_q) == '0);
   // R10
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !pend);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_LINES      = 128,
   parameter int LINES_PER_WORD = 32,
   parameter int ADDR_W         = 12,
   parameter int WIN_OFS        = 'h400,
   parameter int LOCK_OFS       = 'h004,
   parameter int STAT_OFS       = 'h020,
   parameter int EN_OFS         = 'h024,
   parameter int BANK_STRIDE    = 8,
   parameter int CFG_OFS        = 'h100,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lock_init,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic                 irq
);

   localparam int NUM_WORDS = NUM_LINES / LINES_PER_WORD;
   localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_OFS);

   if (LINES_PER_WORD < 1 || LINES_PER_WORD > 32) begin : g_bad_lpw
      $error("LINES_PER_WORD must be 1..32");
   end
   if (NUM_LINES % LINES_PER_WORD != 0) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of LINES_PER_WORD");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WIN_OFS + CFG_OFS + 4 * NUM_LINES > (1 << ADDR_W)) begin : g_bad_map
      $error("configuration window exceeds address space");
   end
   if (LOCK_OFS + 4 * NUM_WORDS > STAT_OFS) begin : g_bad_lock
      $error("lock words overlap status words");
   end

   logic [ADDR_W-1:0]  rel;
   logic               in_win;
   line_cfg_t          wr_cfg;
   logic [NUM_LINES-1:0] cfg_hit, lock_vec, evt_vec;
   logic [31:0]        cfg_word [NUM_LINES];
   logic [NUM_WORDS-1:0] st_hit, en_hit, lk_hit, pend_vec;
   logic [LINES_PER_WORD-1:0] st_word [NUM_WORDS];
   logic [LINES_PER_WORD-1:0] en_word [NUM_WORDS];
   logic [31:0]        rd_mux;

   assign rel    = addr - WIN_A;
   assign in_win = (addr >= WIN_A);
   assign wr_cfg = '{trig:   wdata[CFG_TRIG_LO +: CFG_TRIG_W],
                     rx_off: wdata[CFG_RXOFF_BIT],
                     tx_off: wdata[CFG_TXOFF_BIT],
                     drv:    wdata[CFG_DRV_BIT]};

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS + 4 * n);
      assign cfg_hit[n] = in_win && (rel == CFG_A);
      gpio_line_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .lock_in  (lock_init[n]),
         .pad_in   (pad_in[n]),
         .cfg_wr   (wr_en && cfg_hit[n]),
         .wr_cfg   (wr_cfg),
         .cfg_word (cfg_word[n]),
         .pad_out  (pad_out[n]),
         .pad_oe   (pad_oe[n]),
         .locked   (lock_vec[n]),
         .evt      (evt_vec[n])
      );
   end

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_OFS + BANK_STRIDE * k);
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS + BANK_STRIDE * k);
      localparam logic [ADDR_W-1:0] LK_A = ADDR_W'(LOCK_OFS + 4 * k);
      assign st_hit[k] = in_win && (rel == ST_A);
      assign en_hit[k] = in_win && (rel == EN_A);
      assign lk_hit[k] = in_win && (rel == LK_A);
      gpio_irq_word #(.WIDTH(LINES_PER_WORD)) u_word (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_vec[k*LINES_PER_WORD +: LINES_PER_WORD]),
         .st_wr  (wr_en && st_hit[k]),
         .en_wr  (wr_en && en_hit[k]),
         .wdata  (wdata[LINES_PER_WORD-1:0]),
         .status (st_word[k]),
         .enable (en_word[k]),
         .pend   (pend_vec[k])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (addr == '0) rd_mux = 32'(WIN_OFS);
      for (int n = 0; n < NUM_LINES; n++)
         if (cfg_hit[n]) rd_mux = cfg_word[n];
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (st_hit[k]) rd_mux = 32'(st_word[k]);
         if (en_hit[k]) rd_mux = 32'(en_word[k]);
         if (lk_hit[k]) rd_mux = 32'(lock_vec[k*LINES_PER_WORD +: LINES_PER_WORD]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   assign irq = |pend_vec;

   // R10
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_vec != '0));

endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

   localparam int HALF = 10;   // 50 MHz

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] lock_init = '0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [11:0]  addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [127:0] pad_in = '0;
   logic [127:0] pad_out, pad_oe;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #HALF clk = ~clk;

   gpio_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .lock_init(lock_init),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   function automatic logic [11:0] a_cfg(int n);  return 12'(32'h500 + 4 * n); endfunction
   function automatic logic [11:0] a_stat(int k); return 12'(32'h420 + 8 * k); endfunction
   function automatic logic [11:0] a_en(int k);   return 12'(32'h424 + 8 * k); endfunction
   function automatic logic [11:0] a_lock(int k); return 12'(32'h404 + 4 * k); endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: issue a read and push the expected result to the scoreboard
   task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: rdata is registered, compare shortly after the capturing edge
   always begin
      @(posedge clk);
      if (rd_en) begin
         #(HALF / 2);
         if (exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(2 * HALF * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      lock_init[64]  = 1'b1;
      lock_init[100] = 1'b1;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      bus_rd(a_cfg(5), 32'h0080_0008, "R1 cfg reset");
      chk(32'(pad_oe), 32'h0, "R1 pad_oe low");
      chk(32'(irq), 32'h0, "R1 irq low");
      bus_rd(a_stat(0), 32'h0, "R1 status reset");
      bus_rd(a_en(2), 32'h0, "R1 enable reset");

      // R2 window offset register
      bus_rd(12'h000, 32'h0000_0400, "R2 window offset");

      // R3 stored fields, pad drive
      bus_wr(a_cfg(0), 32'hFFFF_FFF7);
      bus_rd(a_cfg(0), 32'h03C0_0011, "R3 stored fields");
      chk(32'(pad_out[0]), 32'h1, "R3 pad_out");
      chk(32'(pad_oe[0]), 32'h1, "R3 pad_oe");

      // R4 synchronised input state
      bus_wr(a_cfg(37), 32'h0080_0008);
      @(negedge clk); pad_in[37] = 1'b1;
      idle(3);
      bus_rd(a_cfg(37), 32'h0080_000A, "R4 input visible");
      bus_wr(a_cfg(37), 32'h0080_0018);
      bus_rd(a_cfg(37), 32'h0080_0018, "R4 receiver off hides input");
      @(negedge clk); pad_in[37] = 1'b0;
      idle(4);

      // R5 rising edge, latency and irq
      bus_wr(a_cfg(37), 32'h0040_0008);
      bus_wr(a_en(1), 32'h0000_0020);
      bus_wr(a_stat(1), 32'h0);
      bus_rd(a_en(1), 32'h0000_0020, "R10 enable readback");
      @(negedge clk); pad_in[37] = 1'b1;
      @(negedge clk); chk(32'(irq), 32'h0, "R5 irq after 1 edge");
      @(negedge clk); chk(32'(irq), 32'h0, "R5 irq after 2 edges");
      @(negedge clk); chk(32'(irq), 32'h1, "R5 irq after 3 edges");
      bus_rd(a_stat(1), 32'h0000_0020, "R5 status line 37");
      bus_wr(a_stat(1), 32'hFFFF_FFFF);
      bus_rd(a_stat(1), 32'h0000_0020, "R8 write 1 keeps");
      bus_wr(a_en(1), 32'h0);
      @(negedge clk); chk(32'(irq), 32'h0, "R10 masked pending");
      bus_wr(a_en(1), 32'h0000_0020);
      @(negedge clk); chk(32'(irq), 32'h1, "R10 unmasked pending");
      bus_wr(a_stat(1), 32'hFFFF_FFDF);
      idle(3);
      bus_rd(a_stat(1), 32'h0, "R5 held level no re-set");
      chk(32'(irq), 32'h0, "R10 irq after ack");

      // R6 / R9 level high on line 127, bank 3 masked
      bus_wr(a_cfg(127), 32'h0000_0008);
      @(negedge clk); pad_in[127] = 1'b1;
      idle(4);
      bus_rd(a_stat(3), 32'h8000_0000, "R8 line 127 at bank3 bit31");
      chk(32'(irq), 32'h0, "R10 masked bank3");
      bus_wr(a_stat(3), 32'h0);
      bus_rd(a_stat(3), 32'h8000_0000, "R9 event beats clear");
      @(negedge clk); pad_in[127] = 1'b0;
      idle(4);
      bus_wr(a_stat(3), 32'h0);
      bus_rd(a_stat(3), 32'h0, "R6 clear after low");

      // R7 disabled triggers on line 0
      bus_wr(a_cfg(0), 32'h0080_0008);
      @(negedge clk); pad_in[0] = 1'b1; idle(4);
      bus_rd(a_stat(0), 32'h0, "R7 trigger off");
      @(negedge clk); pad_in[0] = 1'b0; idle(4);
      bus_wr(a_cfg(0), 32'h03C0_0008);
      @(negedge clk); pad_in[0] = 1'b1; idle(4);
      bus_rd(a_stat(0), 32'h0, "R7 unsupported code");
      @(negedge clk); pad_in[0] = 1'b0; idle(4);
      bus_wr(a_cfg(0), 32'h0040_0018);
      @(negedge clk); pad_in[0] = 1'b1; idle(4);
      bus_rd(a_stat(0), 32'h0, "R7 receiver off");
      @(negedge clk); pad_in[0] = 1'b0; idle(4);

      // R11 lock
      bus_rd(a_lock(2), 32'h0000_0001, "R11 lock word 2");
      bus_rd(a_lock(3), 32'h0000_0010, "R11 lock word 3");
      bus_rd(a_lock(0), 32'h0, "R11 lock word 0");
      bus_wr(a_cfg(64), 32'h0000_0001);
      bus_rd(a_cfg(64), 32'h0080_0008, "R11 locked cfg unchanged");
      chk(32'(pad_oe[64]), 32'h0, "R11 locked pad_oe");
      bus_wr(a_lock(2), 32'h0);
      bus_rd(a_lock(2), 32'h0000_0001, "R11 lock write ignored");
      bus_wr(a_cfg(65), 32'h0000_0001);
      bus_rd(a_cfg(65), 32'h0000_0001, "R11 unlocked neighbour writes");

      idle(4);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard left %0d reads", exp_q.size());
      end
      summary();
   end

endmodule